// File: doc/BRIEF.md
# Protected Power Mode Controller

This block sits beside a small processor core and decides how fast, and whether, the core and its peripherals are clocked. Software programs it through a narrow register port. A mode register holds an idle request, a slow-down enable, a power-down request, a wake-up configuration bit and a four-bit divider select. A key register guards the sensitive mode bits. A peripheral gate register switches off the clock of each peripheral separately.

The controller tracks four operating states: full-speed run, slow-down, idle, and the compound slow-down-idle. Idle stops the core clock until a pending interrupt or a reset arrives. Slow-down forwards the chosen divider to the clock generator, which sits outside this block. Once the idle request is set it clears itself on wake-up. The slow-down bit cannot be cleared while the core is idle, so the compound state is always left by waking first and then leaving slow-down.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset every register reads 0. The core clock is enabled, the divider output is 0, power-down and wake-up outputs are low, every peripheral clock is enabled and the key is locked.
- R2: The key register is at address 1. Writing 0x98 opens the key and writing 0xA8 closes it. Any other value leaves the key unchanged. Bit 0 of a key read is 1 while open, and all other read bits are 0.
- R3: The mode register is at address 0, with bit 1 slow-down, bit 2 power-down and bit 3 wake-up configuration. These three bits change only on a write made while the key is open. While the key is closed such writes leave them unchanged.
- R4: Mode bits 7:4 hold the divider select. `clk_div_sel` equals this field while slow-down is on and is 0 otherwise. A write to the field takes effect only while the controller is in the run state.
- R5: Slow-down stays on until a write with bit 1 cleared is made while the key is open and the core is not idle.
- R6: Writing mode bit 0 as 1 drops `cpu_clk_en` from the next cycle onward. Writing bit 0 as 0 has no effect.
- R7: While idle, a high `irq_pend` at a clock edge clears the idle bit at that edge. The idle bit then reads back 0 and `cpu_clk_en` is 1.
- R8: Setting idle while slow-down is on gives state 3 (slow-down-idle); `pm_state` uses 0 run, 1 slow, 2 idle, 3 slow-idle. In idle a write clearing slow-down is ignored, and an interrupt returns the controller to state 1 with the divider unchanged.
- R9: The gate register is at address 2. Bit i set to 1 drives `periph_clk_en[i]` low from the next cycle, and the register reads back as written.
- R10: Asserting reset in any state returns the controller to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_pend | input | 1 | Any enabled interrupt is pending |
| cpu_clk_en | output | 1 | Core clock enable |
| clk_div_sel | output | 4 | Divider select sent to the clock generator |
| pd_req | output | 1 | Power-down request |
| wake_cfg | output | 1 | Wake-up configuration bit |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| pm_state | output | 2 | Current operating state |

## Verification
Every state bit drives a port directly, so a wrong internal state shows up in the cycle after the faulty edge. A wrong key state appears on read-back bit 0 and through whether protected writes take effect. A slow-down bit cleared too early or too late changes `clk_div_sel` and `pm_state` at once. A lost or stuck idle bit shows up on `cpu_clk_en` at the first interrupt edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_KEY  = 2'd1;
  localparam logic [ADDR_W-1:0] A_GATE = 2'd2;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 8'h98;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 8'hA8;

  localparam int B_IDLE = 0;
  localparam int B_SLOW = 1;
  localparam int B_PD   = 2;
  localparam int B_WAKE = 3;
  localparam int B_DIV  = 4;

  typedef enum logic [1:0] {
    PM_RUN       = 2'd0,
    PM_SLOW      = 2'd1,
    PM_IDLE      = 2'd2,
    PM_SLOW_IDLE = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pmc_key_lock.sv
module pmc_key_lock
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_open
);
  logic open_q, open_d;

  always_comb begin
    open_d = open_q;
    if (wr_key) begin
      if (wdata == KEY_OPEN)       open_d = 1'b1;
      else if (wdata == KEY_CLOSE) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign key_open = open_q;

  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_key |=> $stable(key_open)); // R2
  AST_KEY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && wdata == KEY_CLOSE) |=> !key_open); // R2
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] wdata,
  input  logic              key_open,
  input  logic              irq_pend,
  output pm_state_e         state,
  output logic [DIV_W-1:0]  div_sel,
  output logic [DIV_W-1:0]  div_field,
  output logic              pd_q,
  output logic              wake_q
);
  pm_state_e        state_q, state_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             pd_d, wake_d;
  logic             idle, slow, idle_d, slow_d;

  assign idle = state_q[1];
  assign slow = state_q[0];

  always_comb begin
    idle_d = idle ? !irq_pend : (wr_mode && wdata[B_IDLE]);
    slow_d = slow;
    if (wr_mode && key_open && !idle) slow_d = wdata[B_SLOW];
    pd_d   = pd_q;
    wake_d = wake_q;
    if (wr_mode && key_open) begin
      pd_d   = wdata[B_PD];
      wake_d = wdata[B_WAKE];
    end
    div_d = div_q;
    if (wr_mode && state_q == PM_RUN) div_d = wdata[B_DIV +: DIV_W];
    state_d = pm_state_e'({idle_d, slow_d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      div_q   <= '0;
      pd_q    <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      pd_q    <= pd_d;
      wake_q  <= wake_d;
    end
  end

  assign state     = state_q;
  assign div_field = div_q;
  assign div_sel   = slow ? div_q : '0;

  AST_LOCK_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !key_open |=> $stable(slow)); // R3
  AST_LOCK_PD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_open |=> $stable({pd_q, wake_q})); // R3
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PM_RUN) |=> $stable(div_q)); // R4
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && irq_pend) |=> !idle); // R7
  AST_SLOW_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(slow)); // R8
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate #(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_gate,
  input  logic [NUM_PERIPH-1:0] wdata,
  output logic [NUM_PERIPH-1:0] gate_q,
  output logic [NUM_PERIPH-1:0] periph_clk_en
);
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
    logic off_d;
    always_comb off_d = wr_gate ? wdata[i] : gate_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q[i] <= 1'b0;
      else        gate_q[i] <= off_d;
    end
    assign periph_clk_en[i] = !gate_q[i];
  end

  AST_GATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gate |=> (periph_clk_en == ~$past(wdata))); // R9
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic                  irq_pend,
  output logic                  cpu_clk_en,
  output logic [3:0]            clk_div_sel,
  output logic                  pd_req,
  output logic                  wake_cfg,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic [1:0]            pm_state
);
  logic             rst_sync_n, key_open;
  logic             wr_mode, wr_key, wr_gate;
  pm_state_e        state;
  logic [DIV_W-1:0] div_field;
  logic [NUM_PERIPH-1:0] gate_q;

  initial begin
    assert (NUM_PERIPH >= 1 && NUM_PERIPH <= DATA_W);
  end

  assign wr_mode = bus_wr && bus_addr == A_MODE;
  assign wr_key  = bus_wr && bus_addr == A_KEY;
  assign wr_gate = bus_wr && bus_addr == A_GATE;

  pmc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pmc_key_lock u_key (
    .clk(clk), .rst_n(rst_sync_n), .wr_key(wr_key), .wdata(bus_wdata),
    .key_open(key_open));

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .wr_mode(wr_mode), .wdata(bus_wdata),
    .key_open(key_open), .irq_pend(irq_pend), .state(state),
    .div_sel(clk_div_sel), .div_field(div_field), .pd_q(pd_req),
    .wake_q(wake_cfg));

  pmc_clk_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .wr_gate(wr_gate),
    .wdata(bus_wdata[NUM_PERIPH-1:0]), .gate_q(gate_q),
    .periph_clk_en(periph_clk_en));

  assign cpu_clk_en = !state[1];
  assign pm_state   = state;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE: begin
        bus_rdata[B_IDLE]           = state[1];
        bus_rdata[B_SLOW]           = state[0];
        bus_rdata[B_PD]             = pd_req;
        bus_rdata[B_WAKE]           = wake_cfg;
        bus_rdata[B_DIV +: DIV_W]   = div_field;
      end
      A_KEY:   bus_rdata[0] = key_open;
      A_GATE:  bus_rdata[NUM_PERIPH-1:0] = gate_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_IDLE_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_mode && bus_wdata[B_IDLE]) |=> !cpu_clk_en); // R6
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_pend = 1'b0;
  logic       cpu_clk_en;
  logic [3:0] clk_div_sel;
  logic       pd_req, wake_cfg;
  logic [7:0] periph_clk_en;
  logic [1:0] pm_state;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic irq_pulse();
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    logic [7:0] v;
    rd(2'd0, v); chk({tag, " mode"}, v, 0);
    rd(2'd1, v); chk({tag, " key"}, v, 0);
    rd(2'd2, v); chk({tag, " gate"}, v, 0);
    chk({tag, " cpu_en"}, cpu_clk_en, 1);
    chk({tag, " div"}, clk_div_sel, 0);
    chk({tag, " pd/wake"}, {pd_req, wake_cfg}, 0);
    chk({tag, " periph"}, periph_clk_en, 8'hFF);
    chk({tag, " state"}, pm_state, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..R10 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    check_reset_state("R1");

    // R3: protected bits ignored while locked; divider still taken in run
    wr(2'd0, 8'h3E);
    rd(2'd0, v); chk("R3 locked write", v, 8'h30);
    chk("R3 locked pd", {pd_req, wake_cfg}, 0);
    chk("R3 locked div out", clk_div_sel, 0);

    // R2: full sweep of key values from both lock states
    for (int k = 0; k < 256; k++) begin
      wr(2'd1, 8'h98);
      wr(2'd1, k[7:0]);
      rd(2'd1, v); chk("R2 from open", v, (k == 8'hA8) ? 0 : 1);
      wr(2'd1, 8'hA8);
      wr(2'd1, k[7:0]);
      rd(2'd1, v); chk("R2 from closed", v, (k == 8'h98) ? 1 : 0);
    end

    // R3 positive: open key lets pd/wake through
    wr(2'd1, 8'h98);
    wr(2'd0, 8'h0C);
    chk("R3 open pd", {pd_req, wake_cfg}, 2'b11);
    wr(2'd0, 8'h00);
    chk("R3 open clear", {pd_req, wake_cfg}, 0);

    // R4/R5: divider sweep with slow-down
    for (int d = 0; d < 16; d++) begin
      logic [3:0] nd;
      nd = ~d[3:0];
      wr(2'd1, 8'h98);
      wr(2'd0, {d[3:0], 4'b0010});
      chk("R4 div out", clk_div_sel, d);
      chk("R4 state slow", pm_state, 1);
      wr(2'd0, {nd, 4'b0010});
      chk("R4 div frozen", clk_div_sel, d);
      wr(2'd1, 8'hA8);
      wr(2'd0, 8'h00);
      chk("R5 locked clear", pm_state, 1);
      wr(2'd1, 8'h98);
      wr(2'd0, {nd, 4'b0000});
      rd(2'd0, v); chk("R5 cleared", v, {d[3:0], 4'b0000});
      chk("R4 div zero", clk_div_sel, 0);
    end

    // R6/R7: plain idle
    wr(2'd0, 8'h01);
    chk("R6 cpu off", cpu_clk_en, 0);
    chk("R6 state idle", pm_state, 2);
    wr(2'd0, 8'h00);
    chk("R6 clear ignored", cpu_clk_en, 0);
    irq_pulse();
    chk("R7 cpu on", cpu_clk_en, 1);
    rd(2'd0, v); chk("R7 idle readback", v[0], 0);
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk);
    chk("R7 irq outside idle", pm_state, 0);
    irq_pend = 1'b0;

    // R8: slow-down-idle entry and ordered exit
    wr(2'd0, 8'h50);
    wr(2'd0, 8'h52);
    wr(2'd0, 8'h53);
    chk("R8 state slow-idle", pm_state, 3);
    chk("R8 div held", clk_div_sel, 5);
    wr(2'd0, 8'h50);
    chk("R8 clear in idle ignored", pm_state, 3);
    irq_pulse();
    chk("R8 back to slow", pm_state, 1);
    chk("R8 div after wake", clk_div_sel, 5);
    wr(2'd0, 8'h50);
    chk("R8 exit to run", pm_state, 0);

    // R9: all gate patterns
    for (int g = 0; g < 256; g++) begin
      wr(2'd2, g[7:0]);
      chk("R9 enables", periph_clk_en, (~g) & 8'hFF);
      rd(2'd2, v); chk("R9 readback", v, g);
    end

    // R10: reset from slow-down-idle with everything set
    wr(2'd1, 8'h98);
    wr(2'd0, 8'hAE);
    wr(2'd0, 8'hAF);
    wr(2'd2, 8'h5A);
    chk("R10 pre state", pm_state, 3);
    do_reset();
    check_reset_state("R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule